// File: doc/BRIEF.md
# DAC Sample Clock Sequencer

This block makes the sample clock for a switched-capacitor DAC. The input clock is divided down to a base period of 1 to 64 cycles. Each sample clock period is a high part of 2 or 4 base periods followed by a low part of 1 to 4 base periods. A period can be active, where the clock pulses, or inactive, where the clock stays low for the whole period.

After it is enabled, the sequencer runs a setup phase of a programmed number of active periods. It then enters a hold phase that repeats a pattern: a programmed number of inactive periods, then one active period. This keeps the DAC refreshed at a lower duty. The hold phase runs until the enable is removed. The sequencer then finishes the period in progress and returns to idle with the clock low. Two status outputs show which phase is running.

The configuration inputs are captured when the sequencer starts. Changes to them while it runs have no effect.

Top module: `dac_smpl_seq`

## Requirements
- R1: After reset, `smpl_clk_o`, `setup_act_o` and `hold_act_o` are all 0.
- R2: One base period lasts `clkdiv_i + 1` input clock cycles, so the 6-bit code gives division by 1 to 64.
- R3: In an active period the sample clock is high for 2 base periods when `hi_sel_i` is 0, and for 4 base periods when it is 1.
- R4: After the high part, the sample clock is low for `lo_code_i + 1` base periods. An inactive period lasts the same total time but stays low throughout.
- R5: A start happens when `en_i` is sampled high while idle. The clock goes high in the cycle after that edge. The setup phase then runs `setup_cnt_i + 1` active periods, with `setup_act_o` at 1 and `hold_act_o` at 0.
- R6: The hold phase follows the setup phase directly, with `hold_act_o` at 1. It repeats `hold_gap_i` inactive periods followed by one active period, so a gap of 0 makes every period active. The gap also separates the last setup pulse from the first hold pulse.
- R7: `en_i` is sampled at the last cycle of each period. If it is 0 there, the sequencer ends that period and goes idle from the next cycle, with the clock low and both status outputs at 0.
- R8: All configuration inputs are captured at the start edge. Changes to them while running do not alter the output sequence.
- R9: `setup_act_o` and `hold_act_o` are never 1 together. `smpl_clk_o` is 1 only while one of them is 1.
- R10: Only an idle sequencer can start. While idle with `en_i` at 0, all outputs stay 0. Hold never passes back to setup without first going idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request |
| clkdiv_i | input | 6 | Base period minus one, in input cycles |
| hi_sel_i | input | 1 | High-time select: 0 gives 2 base periods, 1 gives 4 |
| lo_code_i | input | 2 | Low time minus one, in base periods |
| setup_cnt_i | input | 4 | Setup active periods minus one |
| hold_gap_i | input | 8 | Inactive periods before each active period in hold |
| smpl_clk_o | output | 1 | Sample clock |
| setup_act_o | output | 1 | Setup phase running |
| hold_act_o | output | 1 | Hold phase running |

## Verification
A wrong divider count or base-period count shows as a pulse edge shifted by at least one input cycle. It appears within the first period after the start edge. A wrong setup counter or hold gap counter moves the setup-to-hold status change, or adds or drops a hold pulse. It appears within one hold pattern, which is at most 256 periods. A stop that is sampled at the wrong time leaves the status bits up, or clears them early, at the period boundary after the enable falls. Every mismatch therefore shows at the ports within a bounded number of periods.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int DIV_W   = 6;
  localparam int LO_W    = 2;
  localparam int SETUP_W = 4;
  localparam int GAP_W   = 8;
  localparam int HI_MAX  = 4;
  localparam int PER_MAX = HI_MAX + (1 << LO_W);
  localparam int BCNT_W  = $clog2(PER_MAX);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;

  typedef struct packed {
    logic [DIV_W-1:0]   div;
    logic               hi_sel;
    logic [LO_W-1:0]    lo;
    logic [SETUP_W-1:0] setup;
    logic [GAP_W-1:0]   gap;
  } cfg_t;
endpackage

// File: rtl/dac_tick_div.sv
module dac_tick_div
  import dac_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/dac_period_gen.sv
module dac_period_gen
  import dac_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic            hi_sel_i,
  input  logic [LO_W-1:0] lo_i,
  output logic            high_o,
  output logic            end_o
);
  localparam int LW = BCNT_W + 1;

  logic [BCNT_W-1:0] bcnt_q;
  logic [LW-1:0]     hi_len, per_len;
  logic              last;

  assign hi_len  = hi_sel_i ? LW'(4) : LW'(2);
  assign per_len = hi_len + LW'(lo_i) + LW'(1);
  assign last    = ({1'b0, bcnt_q} == (per_len - LW'(1)));
  assign high_o  = ({1'b0, bcnt_q} < hi_len);
  assign end_o   = tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt_q <= '0;
    else if (clr_i)  bcnt_q <= '0;
    else if (end_o)  bcnt_q <= '0;
    else if (tick_i) bcnt_q <= bcnt_q + BCNT_W'(1);
  end
endmodule

// File: rtl/dac_phase_seq.sv
module dac_phase_seq
  import dac_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               end_i,
  input  logic [SETUP_W-1:0] setup_i,
  input  logic [GAP_W-1:0]   gap_i,
  output logic               start_o,
  output logic               run_o,
  output logic               act_o,
  output logic               setup_o,
  output logic               hold_o
);
  phase_e             ph_q;
  logic [SETUP_W-1:0] scnt_q;
  logic [GAP_W-1:0]   gcnt_q, gcnt_n;
  logic               act_q;

  assign start_o = (ph_q == PH_IDLE) && en_i;
  assign run_o   = (ph_q != PH_IDLE);
  assign act_o   = act_q;
  assign setup_o = (ph_q == PH_SETUP);
  assign hold_o  = (ph_q == PH_HOLD);
  assign gcnt_n  = gcnt_q + GAP_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      scnt_q <= '0;
      gcnt_q <= '0;
      act_q  <= 1'b0;
    end else if (start_o) begin
      ph_q   <= PH_SETUP;
      scnt_q <= '0;
      gcnt_q <= '0;
      act_q  <= 1'b1;
    end else if (run_o && end_i) begin
      if (!en_i) begin
        ph_q  <= PH_IDLE;
        act_q <= 1'b0;
      end else if (ph_q == PH_SETUP && scnt_q != setup_i) begin
        scnt_q <= scnt_q + SETUP_W'(1);
        act_q  <= 1'b1;
      end else begin
        ph_q <= PH_HOLD;
        if (act_q) begin
          // gap count restarts after every pulse
          gcnt_q <= '0;
          act_q  <= (gap_i == '0);
        end else begin
          gcnt_q <= gcnt_n;
          act_q  <= (gcnt_n == gap_i);
        end
      end
    end
  end
endmodule

// File: rtl/dac_smpl_seq.sv
module dac_smpl_seq
  import dac_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [DIV_W-1:0]   clkdiv_i,
  input  logic               hi_sel_i,
  input  logic [LO_W-1:0]    lo_code_i,
  input  logic [SETUP_W-1:0] setup_cnt_i,
  input  logic [GAP_W-1:0]   hold_gap_i,
  output logic               smpl_clk_o,
  output logic               setup_act_o,
  output logic               hold_act_o
);
  cfg_t cfg_q;
  logic start, run, act, tick, high, per_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (start) begin
      cfg_q.div    <= clkdiv_i;
      cfg_q.hi_sel <= hi_sel_i;
      cfg_q.lo     <= lo_code_i;
      cfg_q.setup  <= setup_cnt_i;
      cfg_q.gap    <= hold_gap_i;
    end
  end

  dac_tick_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!run),
    .div_i  (cfg_q.div),
    .tick_o (tick)
  );

  dac_period_gen u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!run),
    .tick_i   (tick),
    .hi_sel_i (cfg_q.hi_sel),
    .lo_i     (cfg_q.lo),
    .high_o   (high),
    .end_o    (per_end)
  );

  dac_phase_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .end_i   (per_end),
    .setup_i (cfg_q.setup),
    .gap_i   (cfg_q.gap),
    .start_o (start),
    .run_o   (run),
    .act_o   (act),
    .setup_o (setup_act_o),
    .hold_o  (hold_act_o)
  );

  assign smpl_clk_o = run && act && high;
endmodule

// File: rtl/dac_smpl_seq_chk.sv
module dac_smpl_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic smpl_clk_o,
  input logic setup_act_o,
  input logic hold_act_o
);
  logic busy;
  assign busy = setup_act_o || hold_act_o;

  // R9
  exclusive_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(setup_act_o && hold_act_o));

  // R9
  clk_needs_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smpl_clk_o |-> busy);

  // R10
  no_hold_to_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_act_o |=> !setup_act_o);

  // R7
  stop_when_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !$past(smpl_clk_o));

  // R3
  min_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smpl_clk_o) |=> smpl_clk_o);

  // R5
  start_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(setup_act_o) |-> !$past(hold_act_o));
endmodule

bind dac_smpl_seq dac_smpl_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smpl_clk_o  (smpl_clk_o),
  .setup_act_o (setup_act_o),
  .hold_act_o  (hold_act_o)
);

// File: tb/dac_smpl_seq_bench.sv
`timescale 1ns/100ps
module dac_smpl_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [5:0] div = '0;
  logic       hs = 1'b0;
  logic [1:0] lo = '0;
  logic [3:0] su = '0;
  logic [7:0] gp = '0;
  logic       sclk, s_act, h_act;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dac_smpl_seq u_dac_smpl_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .clkdiv_i    (div),
    .hi_sel_i    (hs),
    .lo_code_i   (lo),
    .setup_cnt_i (su),
    .hold_gap_i  (gp),
    .smpl_clk_o  (sclk),
    .setup_act_o (s_act),
    .hold_act_o  (h_act)
  );

  task automatic check(input logic act, input logic exp, input string tag, input int k);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0b expected=%0b", tag, k, act, exp);
    end
  endtask

  // R2 R3 R4 R5 R6 R7 R8: per-cycle compare against an arithmetic model
  task automatic run_cfg(input int dv, input int h, input int lc, input int sn, input int gn);
    int t, hi, per, pt, nper, e, koff;
    t = dv + 1;
    hi = h ? 4 : 2;
    per = hi + lc + 1;
    pt = per * t;
    nper = sn + 1 + 2 * (gn + 1) + 1;
    e = nper * pt;
    koff = e - pt + pt / 2;
    div = 6'(dv); hs = h[0]; lo = 2'(lc); su = 4'(sn); gp = 8'(gn);
    en = 1'b1;
    for (int k = 0; k <= e + 2; k++) begin
      int p, w;
      logic ex_act, ex_clk, ex_su, ex_ho;
      @(posedge clk);
      @(negedge clk);
      p = k / pt;
      w = k % pt;
      ex_act = (p <= sn) ? 1'b1 : (((p - sn - 1) % (gn + 1)) == gn);
      ex_su  = (k < e) && (p <= sn);
      ex_ho  = (k < e) && (p > sn);
      ex_clk = (k < e) && ex_act && (w < hi * t);
      if (k >= e) begin
        check(sclk, 1'b0, "R7 clk", k);
        check(s_act, 1'b0, "R7 setup", k);
        check(h_act, 1'b0, "R7 hold", k);
      end else begin
        check(sclk, ex_clk, (w < hi * t) ? "R3 R8 clk high part" : "R4 R8 clk low part", k);
        check(s_act, ex_su, "R5 setup status", k);
        check(h_act, ex_ho, "R6 hold status", k);
        check(s_act && h_act, 1'b0, "R9 exclusive", k);
      end
      if (k == 1) begin
        div = ~div; hs = ~hs; lo = ~lo; su = ~su; gp = ~gp;
      end
      if (k == koff) en = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check(s_act || h_act || sclk, 1'b0, "R10 idle stays", 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sclk, 1'b0, "R1 clk", 0);
    check(s_act, 1'b0, "R1 setup", 0);
    check(h_act, 1'b0, "R1 hold", 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(s_act || h_act || sclk, 1'b0, "R10 idle with en low", 0);
    end
    foreach (div_set[i]) ;
    for (int dv = 0; dv < 3; dv++)
      for (int h = 0; h < 2; h++)
        for (int lc = 0; lc < 4; lc += 3)
          for (int sn = 0; sn < 3; sn += 2)
            for (int gi = 0; gi < 3; gi++)
              run_cfg((dv == 2) ? 3 : dv, h, lc, sn, (gi == 2) ? 3 : gi);
    run_cfg(0, 1, 3, 15, 20);
    run_cfg(63, 0, 0, 0, 0);
    run_cfg(5, 1, 1, 3, 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int div_set[1];
endmodule